// File: doc/BRIEF.md
# Initiator Data-Out Byte Handshake Engine

This block is the initiator side of the data-out transfer on a narrow 8-bit parallel bus. Bytes come in on a valid/ready stream, each marked with a last flag. The engine places each byte on the bus data lines and signals it with a request strobe. The target answers each byte with an acknowledge.

The engine has two handshake styles. In the interlocked style, each byte runs a full four-edge exchange: data is driven and the request is raised, the acknowledge rises, the request falls, and the acknowledge falls. Only then may the next byte enter. In the windowed style, each byte is a single-cycle request pulse. The engine keeps a count of pulses not yet acknowledged and stops taking bytes while that count has reached the programmed window. This lets a burst of bytes cross a long cable without waiting a round trip per byte. The windowed style is selected by `sync_en` together with a nonzero `sync_offset`.

The controller is a state machine with six states:
- IDLE waits for a byte.
- AREQ holds the request until the acknowledge is seen high.
- AREL holds the request low until the acknowledge is seen low.
- SPULSE drives one request pulse.
- DRAIN waits for the outstanding count to reach zero after the final byte.
- DONE raises the completion pulse.

The transitions are:
- IDLE→AREQ on an accepted byte in the interlocked style.
- IDLE→SPULSE on an accepted byte in the windowed style.
- AREQ→AREL when the acknowledge is high.
- AREL→IDLE when the acknowledge is low and the byte was not the last.
- AREL→DONE when the acknowledge is low and the byte was the last.
- SPULSE→IDLE when the byte was not the last.
- SPULSE→DRAIN when the byte was the last.
- DRAIN→DONE when the count is zero.
- DONE→IDLE always.

Top module: `bytelink_tx`

## Requirements
- R1: After reset, `bus_req`, `xfer_done` and `outstanding` are all 0, and `src_ready` is 1.
- R2: In the interlocked style, a byte accepted at a clock edge raises `bus_req` from the next cycle. `bus_req` stays high until `bus_ack` is sampled 1, then drops for the following cycle. No new byte is accepted until `bus_ack` has been sampled 0.
- R3: While `bus_req` is high, `bus_data` holds the accepted byte unchanged. Bytes appear on the bus in stream order.
- R4: `sync_en`=1 with `sync_offset`=0 behaves exactly like the interlocked style.
- R5: In the windowed style, each accepted byte produces exactly one request pulse, one cycle wide, in the cycle after acceptance.
- R6: `outstanding` rises by one at the edge ending each request pulse. It falls by one at each edge where `bus_ack` is sampled 1 after being 0. If both happen at the same edge, it is unchanged.
- R7: In the windowed style, `src_ready` is 0 whenever `outstanding` is at or above the effective window.
- R8: A `sync_offset` above 8 gives an effective window of 8.
- R9: `xfer_done` is a one-cycle pulse.
  - In the interlocked style, it comes in the cycle after the last byte's acknowledge is sampled low.
  - In the windowed style, it comes one cycle after `outstanding` reads 0 following the last byte's pulse.
- R10: An acknowledge rising edge while `outstanding` is 0 has no effect: the count stays 0.
- R11: `src_ready` is 0 whenever a byte is in flight, that is, in every state other than IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Stream byte valid |
| src_data | input | 8 | Stream byte |
| src_last | input | 1 | Marks the final byte of a transfer |
| src_ready | output | 1 | Engine takes the byte at this edge |
| bus_data | output | 8 | Bus data lines |
| bus_req | output | 1 | Request strobe |
| bus_ack | input | 1 | Acknowledge from the target |
| sync_en | input | 1 | Selects the windowed style |
| sync_offset | input | 4 | Window size; 0 forces interlocked behaviour |
| xfer_done | output | 1 | Completion pulse |
| outstanding | output | 4 | Request pulses not yet acknowledged |

## Verification
The properties assume that `sync_en` and `sync_offset` are held steady for the whole of a transfer. They also assume that `bus_ack` is synchronous to `clk` and that, in the windowed style, acknowledge pulses are separated by at least one low cycle.

The bench changes the style and window only while reset is asserted. Its target model raises acknowledges only in response to observed requests, and it always returns the line low for a cycle between windowed pulses. The one deliberate exception is a spurious acknowledge driven while nothing is outstanding, which exercises R10.

// File: rtl/bytelink_pkg.sv
package bytelink_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AREQ,
        ST_AREL,
        ST_SPULSE,
        ST_DRAIN,
        ST_DONE
    } blk_state_e;

endpackage

// File: rtl/bytelink_ackedge.sv
module bytelink_ackedge (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic rise_o
);

    logic ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_i;
    end

    // A new acknowledge is a high level that was low one cycle earlier.
    assign rise_o = ack_i & ~ack_q;

endmodule

// File: rtl/bytelink_credit.sv
module bytelink_credit #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;
    logic          dec_ok;

    // A decrement is honoured only when something is outstanding (no underflow).
    assign dec_ok = dec_i && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc_i, dec_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bytelink_window.sv
module bytelink_window #(
    parameter int MAX_OFFSET = 8,
    parameter int OW         = 4
) (
    input  logic          sync_en,
    input  logic [OW-1:0] offset_i,
    input  logic [OW-1:0] cnt_i,
    output logic          sync_now,
    output logic          has_room
);

    localparam logic [OW-1:0] CAP = OW'(MAX_OFFSET);

    logic [OW-1:0] eff;

    always_comb begin
        eff      = (offset_i > CAP) ? CAP : offset_i;
        sync_now = sync_en && (offset_i != '0);
        has_room = (cnt_i < eff);
    end

endmodule

// File: rtl/bytelink_seq.sv
module bytelink_seq
    import bytelink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    input  logic              sync_now,
    input  logic              has_room,
    input  logic              ack_lvl,
    input  logic              cnt_zero,
    output logic              src_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_req,
    output logic              xfer_done,
    output logic              pulse_sent
);

    blk_state_e        st_q, st_d;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              wsync_q;
    logic              take;

    assign take = src_valid && src_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Byte holding register and style chosen at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            last_q  <= 1'b0;
            wsync_q <= 1'b0;
        end else if (take) begin
            data_q  <= src_data;
            last_q  <= src_last;
            wsync_q <= sync_now;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (take) st_d = sync_now ? ST_SPULSE : ST_AREQ;
            ST_AREQ:   if (ack_lvl) st_d = ST_AREL;
            ST_AREL:   if (!ack_lvl) st_d = last_q ? ST_DONE : ST_IDLE;
            ST_SPULSE: st_d = last_q ? ST_DRAIN : ST_IDLE;
            ST_DRAIN:  if (cnt_zero) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        src_ready  = 1'b0;
        bus_req    = 1'b0;
        xfer_done  = 1'b0;
        pulse_sent = 1'b0;
        unique case (st_q)
            ST_IDLE:   src_ready = !sync_now || has_room;
            ST_AREQ:   bus_req = 1'b1;
            ST_AREL:   bus_req = 1'b0;
            ST_SPULSE: begin
                bus_req    = 1'b1;
                pulse_sent = wsync_q;
            end
            ST_DRAIN:  bus_req = 1'b0;
            ST_DONE:   xfer_done = 1'b1;
            default:   bus_req = 1'b0;
        endcase
    end

    assign bus_data = data_q;

endmodule

// File: rtl/bytelink_tx.sv
module bytelink_tx #(
    parameter int DATA_W     = 8,
    parameter int MAX_OFFSET = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 src_valid,
    input  logic [DATA_W-1:0]                    src_data,
    input  logic                                 src_last,
    output logic                                 src_ready,
    output logic [DATA_W-1:0]                    bus_data,
    output logic                                 bus_req,
    input  logic                                 bus_ack,
    input  logic                                 sync_en,
    input  logic [$clog2(MAX_OFFSET+1)-1:0]      sync_offset,
    output logic                                 xfer_done,
    output logic [$clog2(MAX_OFFSET+1)-1:0]      outstanding
);

    localparam int OFF_W = $clog2(MAX_OFFSET + 1);

    logic             ack_rise;
    logic             pulse_sent;
    logic             cnt_zero;
    logic             sync_now;
    logic             has_room;
    logic [OFF_W-1:0] cnt;

    bytelink_ackedge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (bus_ack),
        .rise_o (ack_rise)
    );

    bytelink_credit #(.CW(OFF_W)) u_credit (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (pulse_sent),
        .dec_i  (ack_rise),
        .cnt_o  (cnt),
        .zero_o (cnt_zero)
    );

    bytelink_window #(.MAX_OFFSET(MAX_OFFSET), .OW(OFF_W)) u_window (
        .sync_en  (sync_en),
        .offset_i (sync_offset),
        .cnt_i    (cnt),
        .sync_now (sync_now),
        .has_room (has_room)
    );

    bytelink_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_last   (src_last),
        .sync_now   (sync_now),
        .has_room   (has_room),
        .ack_lvl    (bus_ack),
        .cnt_zero   (cnt_zero),
        .src_ready  (src_ready),
        .bus_data   (bus_data),
        .bus_req    (bus_req),
        .xfer_done  (xfer_done),
        .pulse_sent (pulse_sent)
    );

    assign outstanding = cnt;

endmodule

// File: rtl/bytelink_tx_chk.sv
module bytelink_tx_chk #(
    parameter int DATA_W     = 8,
    parameter int MAX_OFFSET = 8,
    parameter int OW         = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              sync_en,
    input logic [OW-1:0]     sync_offset,
    input logic              xfer_done,
    input logic [OW-1:0]     outstanding
);

    logic          wmode;
    logic [OW-1:0] win;

    assign wmode = sync_en && (sync_offset != '0);
    assign win   = (sync_offset > OW'(MAX_OFFSET)) ? OW'(MAX_OFFSET) : sync_offset;

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !wmode && !bus_ack) |=> bus_req);

    a_r2_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !wmode && bus_ack) |=> !bus_req);

    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_data));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && wmode) |=> !bus_req);

    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (outstanding == $past(outstanding)) ||
                 (outstanding == $past(outstanding) + OW'(1)) ||
                 (outstanding + OW'(1) == $past(outstanding)));

    a_r7_within_window: assert property (@(posedge clk) disable iff (!rst_n)
        wmode |-> (outstanding <= win));

    a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (outstanding == '0) && !bus_req);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == '0 && !bus_req) |=> (outstanding == '0));

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || xfer_done) |-> !src_ready);

endmodule

bind bytelink_tx bytelink_tx_chk #(
    .DATA_W     (DATA_W),
    .MAX_OFFSET (MAX_OFFSET),
    .OW         (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_ready   (src_ready),
    .bus_data    (bus_data),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .sync_en     (sync_en),
    .sync_offset (sync_offset),
    .xfer_done   (xfer_done),
    .outstanding (outstanding)
);

// File: tb/bytelink_tx_tb.sv
module bytelink_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic [7:0] bus_data;
    logic       bus_req;
    logic       bus_ack = 1'b0;
    logic       sync_en = 1'b0;
    logic [3:0] sync_offset = 4'd0;
    logic       xfer_done;
    logic [3:0] outstanding;

    always #10 clk = ~clk;

    bytelink_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_valid   (src_valid),
        .src_data    (src_data),
        .src_last    (src_last),
        .src_ready   (src_ready),
        .bus_data    (bus_data),
        .bus_req     (bus_req),
        .bus_ack     (bus_ack),
        .sync_en     (sync_en),
        .sync_offset (sync_offset),
        .xfer_done   (xfer_done),
        .outstanding (outstanding)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Source stream
    int dq[$];
    bit lq[$];
    bit gap_en = 0;

    // Target responder: 0 interlocked, 1 windowed pulses, 2 manual
    int resp_mode = 0;
    int adelay = 0;
    int sdelay = 0;
    int await_n = 0;
    bit hold = 0;
    int pq[$];

    // Statistics
    int done_cnt = 0;
    int pulse_cnt = 0;
    int max_pend = 0;
    bit req_prev = 0;

    // Reference model: 0 idle, 1 req wait-high, 2 wait-low, 3 pulse, 4 drain, 5 done
    int mst = 0;
    int mcnt = 0;
    int mdata = 0;
    bit mlast = 0;
    bit mackp = 0;

    function automatic int eff_off();
        return (sync_offset > 4'd8) ? 8 : int'(sync_offset);
    endfunction

    function automatic bit wmode();
        return sync_en && (sync_offset != 4'd0);
    endfunction

    function automatic bit m_ready();
        return (mst == 0) && (!wmode() || mcnt < eff_off());
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        int nst;
        int dec;
        if (!rst_n) begin
            mst = 0; mcnt = 0; mackp = 0;
        end else begin
            rise  = bus_ack && !mackp;
            mackp = bus_ack;
            nst   = mst;
            case (mst)
                0: if (src_valid && m_ready()) begin
                       mdata = src_data;
                       mlast = src_last;
                       nst   = wmode() ? 3 : 1;
                       void'(dq.pop_front());
                       void'(lq.pop_front());
                   end
                1: if (bus_ack) nst = 2;
                2: if (!bus_ack) nst = mlast ? 5 : 0;
                3: nst = mlast ? 4 : 0;
                4: if (mcnt == 0) nst = 5;
                5: nst = 0;
                default: nst = 0;
            endcase
            dec  = (rise && mcnt > 0) ? 1 : 0;
            mcnt = mcnt + ((mst == 3) ? 1 : 0) - dec;
            mst  = nst;
        end
    end

    always @(negedge clk) begin
        bit exp_req;
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
        if (rst_n) begin
            exp_req = (mst == 1) || (mst == 3);
            check(bus_req == exp_req, "R2/R5 bus_req", bus_req, exp_req);
            check(src_ready == m_ready(), "R7/R11 src_ready", src_ready, m_ready());
            check(xfer_done == (mst == 5), "R9 xfer_done", xfer_done, mst == 5);
            check(int'(outstanding) == mcnt, "R6 outstanding", outstanding, mcnt);
            if (exp_req) check(int'(bus_data) == mdata, "R3 bus_data", bus_data, mdata);
            if (xfer_done) done_cnt++;
            if (bus_req && !req_prev) pulse_cnt++;
            if (int'(outstanding) > max_pend) max_pend = outstanding;
            req_prev = bus_req;
            case (resp_mode)
                0: begin
                    if (bus_req != bus_ack) begin
                        if (await_n >= adelay) begin bus_ack = bus_req; await_n = 0; end
                        else await_n++;
                    end else await_n = 0;
                end
                1: begin
                    if (bus_req) pq.push_back(cyc + sdelay);
                    if (bus_ack) bus_ack = 1'b0;
                    else if (!hold && pq.size() > 0 && pq[0] <= cyc) begin
                        bus_ack = 1'b1;
                        void'(pq.pop_front());
                    end
                end
                default: ;
            endcase
        end
        if (dq.size() > 0 && !(gap_en && (cyc % 3 == 0))) begin
            src_valid = 1'b1;
            src_data  = dq[0][7:0];
            src_last  = lq[0];
        end else begin
            src_valid = 1'b0;
        end
    end

    task automatic do_reset(input bit se, input int off, input int rm);
        @(posedge clk); #5;
        rst_n = 1'b0;
        bus_ack = 1'b0;
        pq.delete(); dq.delete(); lq.delete();
        done_cnt = 0; pulse_cnt = 0; max_pend = 0; req_prev = 0;
        hold = 0; await_n = 0;
        sync_en = se;
        sync_offset = off[3:0];
        resp_mode = rm;
        repeat (2) @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk); #1;
        check(bus_req == 1'b0, "R1 reset bus_req", bus_req, 0);
        check(xfer_done == 1'b0, "R1 reset xfer_done", xfer_done, 0);
        check(outstanding == 4'd0, "R1 reset outstanding", outstanding, 0);
        check(src_ready == 1'b1, "R1 reset src_ready", src_ready, 1);
    endtask

    task automatic push_bytes(input int n, input int base);
        for (int k = 0; k < n; k++) begin
            dq.push_back((base + k * 37) & 8'hFF);
            lq.push_back(k == n - 1);
        end
    endtask

    task automatic finish_xfer(input int n, input string tag);
        while (done_cnt == 0) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
        check(pulse_cnt == n, {tag, " bytes sent"}, pulse_cnt, n);
        check(outstanding == 4'd0, "R6 drained", outstanding, 0);
    endtask

    task automatic run(input bit se, input int off, input int rm, input int ad,
                       input int sd, input int n, input bit gaps, input int base);
        do_reset(se, off, rm);
        adelay = ad; sdelay = sd; gap_en = gaps;
        push_bytes(n, base);
        finish_xfer(n, (rm == 1) ? "R5" : "R2");
        if (rm == 1) begin
            check(max_pend <= ((off > 8) ? 8 : off), "R7 window bound", max_pend,
                  (off > 8) ? 8 : off);
            check(max_pend >= 1, "R6 count rose", max_pend, 1);
        end else begin
            check(max_pend == 0, "R2/R4 no credit use", max_pend, 0);
        end
    endtask

    initial begin
        // R2: interlocked, immediate target
        run(1'b0, 0, 0, 0, 0, 5, 1'b0, 8'h11);
        // R2: interlocked, slow target, gaps in the stream
        run(1'b0, 5, 0, 3, 0, 4, 1'b1, 8'hA0);
        // R4: window requested but offset zero
        run(1'b1, 0, 0, 2, 0, 3, 1'b0, 8'h5C);
        // R5/R7: window of 3, slow acknowledges force stalls
        run(1'b1, 3, 1, 0, 6, 10, 1'b0, 8'h03);
        // R5/R7: window of 1
        run(1'b1, 1, 1, 0, 2, 6, 1'b1, 8'hF0);
        // R5: window of 8, fast acknowledges, gaps
        run(1'b1, 8, 1, 0, 1, 9, 1'b1, 8'h77);

        // R8: offset 12 clamps to 8, acknowledges withheld
        do_reset(1'b1, 12, 1);
        sdelay = 1; gap_en = 0;
        hold = 1;
        push_bytes(12, 8'h40);
        repeat (40) @(posedge clk);
        @(negedge clk); #1;
        check(outstanding == 4'd8, "R8 clamp at 8", outstanding, 8);
        check(src_ready == 1'b0, "R7 stalled at window", src_ready, 0);
        hold = 0;
        finish_xfer(12, "R8");
        check(max_pend == 8, "R8 peak outstanding", max_pend, 8);

        // R10: spurious acknowledge with nothing outstanding
        do_reset(1'b1, 2, 2);
        @(posedge clk); #5 bus_ack = 1'b1;
        @(posedge clk); #5 bus_ack = 1'b0;
        @(negedge clk); #1;
        check(outstanding == 4'd0, "R10 spurious ack ignored", outstanding, 0);
        check(src_ready == 1'b1, "R10 still ready", src_ready, 1);
        resp_mode = 1; sdelay = 2;
        push_bytes(3, 8'hC3);
        finish_xfer(3, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule